// File: doc/BRIEF.md
# Sensor Register SPI Master with Regime-Dependent Frame Timing

This block is the master side of a 16-bit register-access link to a sensor. A local client places a read or write request on a request/response port: a 6-bit register address, a write payload and a write flag, then a single-cycle start. The block builds the outgoing command word and shifts it out in clock-polarity-1, clock-phase-1 mode. At the same time it captures the 16-bit word the sensor returns and hands it back with a one-cycle completion pulse.

The sensor's timing limits depend on how fast it samples. An 8-bit sample-period code is latched with each request. A code of 0x07 or below selects the fast regime: a faster serial clock, but a shorter minimum chip-select-high stall and frame-to-frame period. A code of 0x08 or above selects the normal regime, which has a slower clock and longer gaps. All delays come from a system-clock frequency parameter and are rounded toward longer times.

A request made while the previous frame's gap is still running is not refused. It is held, and the frame starts as soon as both gap conditions are met, with busy asserted throughout.

Top module: `sensor_spi_master`

## Requirements
- R1: Each frame carries 16 bits, MSB first, on spi_mosi. Bit 15 is the write flag (1 = write, 0 = read), bits 14:9 are the address (A5 at bit 14), and bits 8:0 are the write payload.
- R2: spi_miso is captured on each of the 16 SCLK rising edges of a frame, MSB first, into rsp_rdata. Bit 15 is the level the slave presents at the chip-select falling edge, before any SCLK edge.
- R3: SCLK is high whenever chip select is high. spi_mosi changes only at SCLK falling edges, so it is stable at every rising edge.
- R4: With a latched code of 0x07 or less, every SCLK high and low phase lasts ceil(CLK_HZ/5e6) clocks (50 clocks at 250 MHz), which keeps SCLK at or below 2.5 MHz.
- R5: With a latched code of 0x08 or more, every SCLK phase lasts ceil(CLK_HZ/2e6) clocks (125 clocks at 250 MHz), which keeps SCLK at or below 1.0 MHz.
- R6: One SCLK half period separates the chip-select fall from the first SCLK falling edge. One half period also separates the last SCLK rising edge from the chip-select rise.
- R7: After a frame, chip select stays high for at least 9 µs (fast) or 12 µs (normal). The next chip-select fall comes no sooner than 32 µs (fast) or 42 µs (normal) after the previous fall. The regime used is that of the finished frame, with microseconds counted as ceil(CLK_HZ/1e6) clocks (2250/3000 and 8000/10500 clocks at 250 MHz).
- R8: rsp_done is high for exactly one clock, one clock after chip select rises. rsp_rdata is valid in that clock, and busy is already low.
- R9: A start that arrives while the gap timers run is held until they expire. busy is high from the clock after start until rsp_done, and high whenever chip select is low.
- R10: The sample-period code is latched at start. Changing it afterwards does not affect the SCLK rate of the frame in progress.
- R11: After reset, chip select and SCLK are high, busy and rsp_done are low, and rsp_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smpl_code | input | 8 | Sample-period code, latched at start |
| req_addr | input | 6 | Register address |
| req_wdata | input | 9 | Write payload |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_start | input | 1 | Single-cycle request, accepted when busy is low |
| busy | output | 1 | Request pending or frame in progress |
| rsp_rdata | output | 16 | Word captured from spi_miso |
| rsp_done | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |

## Verification
The assertions assume three things about the inputs. req_start is raised only while busy is low. The slave moves spi_miso only at the chip-select falling edge and after SCLK falling edges, and holds it for at least the half period up to the next rising edge, which covers the synchronizer delay. smpl_code is settled in the cycle req_start is sampled. The bench keeps within these limits in three ways. Its driver waits for busy to drop before each request. Its slave model changes spi_miso only on those two edges. It changes smpl_code only after start has been taken, and does so on purpose to exercise the latching.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GAP,
      ST_LEAD,
      ST_LOW,
      ST_HIGH,
      ST_FIN
   } ssm_state_e;

   localparam int unsigned FAST_MAX_CODE  = 7;
   localparam int unsigned SCLK_FAST_HZ   = 2_500_000;
   localparam int unsigned SCLK_NORM_HZ   = 1_000_000;
   localparam int unsigned STALL_FAST_US  = 9;
   localparam int unsigned STALL_NORM_US  = 12;
   localparam int unsigned PERIOD_FAST_US = 32;
   localparam int unsigned PERIOD_NORM_US = 42;

   function automatic int unsigned ceil_div(input int unsigned n, input int unsigned d);
      return (n + d - 1) / d;
   endfunction

endpackage

// File: rtl/ssm_regime.sv
module ssm_regime #(
   parameter int unsigned CLK_HZ = 250_000_000,
   parameter int unsigned CODE_W = 8,
   parameter int unsigned CNT_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [CNT_W-1:0]  half_cyc_o,
   output logic [CNT_W-1:0]  stall_cyc_o,
   output logic [CNT_W-1:0]  period_cyc_o
);
   import ssm_pkg::*;

   localparam int unsigned CYC_US   = ceil_div(CLK_HZ, 1_000_000);
   localparam int unsigned HALF_F   = ceil_div(CLK_HZ, 2 * SCLK_FAST_HZ);
   localparam int unsigned HALF_N   = ceil_div(CLK_HZ, 2 * SCLK_NORM_HZ);
   localparam int unsigned STALL_F  = STALL_FAST_US * CYC_US;
   localparam int unsigned STALL_N  = STALL_NORM_US * CYC_US;
   localparam int unsigned PERIOD_F = PERIOD_FAST_US * CYC_US;
   localparam int unsigned PERIOD_N = PERIOD_NORM_US * CYC_US;

   generate
      if (PERIOD_N >= (1 << CNT_W)) begin : g_bad_width
         $error("ssm_regime: CNT_W too narrow for the normal-regime period");
      end
      if (HALF_F < 1) begin : g_bad_clk
         $error("ssm_regime: clock too slow for the fast SCLK ceiling");
      end
   endgenerate

   logic fast_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fast_q <= 1'b1;
      else if (latch_i) fast_q <= (code_i <= CODE_W'(FAST_MAX_CODE));
   end

   assign half_cyc_o   = fast_q ? CNT_W'(HALF_F)   : CNT_W'(HALF_N);
   assign stall_cyc_o  = fast_q ? CNT_W'(STALL_F)  : CNT_W'(STALL_N);
   assign period_cyc_o = fast_q ? CNT_W'(PERIOD_F) : CNT_W'(PERIOD_N);

   // R10: the regime only moves when a request is latched
   a_r10_regime_held: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_i |=> $stable(fast_q));

endmodule

// File: rtl/ssm_gap_timer.sv
module ssm_gap_timer #(
   parameter int unsigned CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_fall_i,
   input  logic             cs_rise_i,
   input  logic [CNT_W-1:0] stall_cyc_i,
   input  logic [CNT_W-1:0] period_cyc_i,
   output logic             ready_o
);
   logic [CNT_W-1:0] stall_cnt;
   logic [CNT_W-1:0] per_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall_cnt <= '0;
         per_cnt   <= '0;
      end else begin
         if (cs_rise_i)            stall_cnt <= stall_cyc_i;
         else if (stall_cnt != '0) stall_cnt <= stall_cnt - 1'b1;
         if (cs_fall_i)            per_cnt   <= period_cyc_i;
         else if (per_cnt != '0)   per_cnt   <= per_cnt - 1'b1;
      end
   end

   assign ready_o = (stall_cnt == '0) && (per_cnt == '0);

   // R7: a fresh stall window blocks the next frame in the following cycle
   a_r7_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise_i && stall_cyc_i > CNT_W'(1)) |=> !ready_o);

endmodule

// File: rtl/ssm_miso_sync.sv
module ssm_miso_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_i,
   output logic dout_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout_o = din_i;
      end else begin : g_sync
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else begin
               q[0] <= din_i;
               for (int i = 1; i < int'(STAGES); i++) q[i] <= q[i-1];
            end
         end
         assign dout_o = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sensor_spi_master.sv
module sensor_spi_master #(
   parameter int unsigned CLK_HZ    = 250_000_000,
   parameter int unsigned FRAME_W   = 16,
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned CODE_W    = 8,
   parameter int unsigned MISO_SYNC = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [CODE_W-1:0]             smpl_code,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [FRAME_W-ADDR_W-2:0]     req_wdata,
   input  logic                          req_write,
   input  logic                          req_start,
   output logic                          busy,
   output logic [FRAME_W-1:0]            rsp_rdata,
   output logic                          rsp_done,
   output logic                          spi_cs_n,
   output logic                          spi_sclk,
   output logic                          spi_mosi,
   input  logic                          spi_miso
);
   import ssm_pkg::*;

   localparam int unsigned DATA_W = FRAME_W - 1 - ADDR_W;
   localparam int unsigned BIT_W  = $clog2(FRAME_W + 1);
   localparam int unsigned CNT_W  = $clog2(PERIOD_NORM_US * ceil_div(CLK_HZ, 1_000_000) + 1);

   generate
      if (FRAME_W < ADDR_W + 2) begin : g_bad_frame
         $error("sensor_spi_master: frame too short for flag, address and payload");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("sensor_spi_master: payload width must be positive");
      end
   endgenerate

   ssm_state_e         state;
   logic [CNT_W-1:0]   cnt;
   logic [BIT_W-1:0]   bitn;
   logic [FRAME_W-1:0] tx_q;
   logic [FRAME_W-1:0] rx_q;
   logic               cs_q, sclk_q, done_q;
   logic [FRAME_W-1:0] rdata_q;

   logic [CNT_W-1:0]   half_cyc, stall_cyc, period_cyc;
   logic               gap_ready, miso_s;
   logic               accept, launch, finish, phase_end;

   assign accept    = (state == ST_IDLE) && req_start;
   assign launch    = (state == ST_GAP) && gap_ready;
   assign phase_end = (cnt == '0);
   assign finish    = (state == ST_HIGH) && phase_end && (bitn == BIT_W'(FRAME_W));

   ssm_regime #(.CLK_HZ(CLK_HZ), .CODE_W(CODE_W), .CNT_W(CNT_W)) regime_i (
      .clk(clk), .rst_n(rst_n), .latch_i(accept), .code_i(smpl_code),
      .half_cyc_o(half_cyc), .stall_cyc_o(stall_cyc), .period_cyc_o(period_cyc));

   ssm_gap_timer #(.CNT_W(CNT_W)) gap_i (
      .clk(clk), .rst_n(rst_n), .cs_fall_i(launch), .cs_rise_i(finish),
      .stall_cyc_i(stall_cyc), .period_cyc_i(period_cyc), .ready_o(gap_ready));

   ssm_miso_sync #(.STAGES(MISO_SYNC)) sync_i (
      .clk(clk), .rst_n(rst_n), .din_i(spi_miso), .dout_o(miso_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         bitn    <= '0;
         tx_q    <= '0;
         rx_q    <= '0;
         cs_q    <= 1'b1;
         sclk_q  <= 1'b1;
         done_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (req_start) begin
               tx_q  <= {req_write, req_addr, req_wdata};
               state <= ST_GAP;
            end
            ST_GAP: if (gap_ready) begin
               cs_q  <= 1'b0;
               cnt   <= half_cyc - 1'b1;
               bitn  <= '0;
               state <= ST_LEAD;
            end
            ST_LEAD: if (phase_end) begin
               sclk_q <= 1'b0;
               cnt    <= half_cyc - 1'b1;
               state  <= ST_LOW;
            end else cnt <= cnt - 1'b1;
            ST_LOW: if (phase_end) begin
               sclk_q <= 1'b1;
               rx_q   <= {rx_q[FRAME_W-2:0], miso_s};
               bitn   <= bitn + 1'b1;
               cnt    <= half_cyc - 1'b1;
               state  <= ST_HIGH;
            end else cnt <= cnt - 1'b1;
            ST_HIGH: if (phase_end) begin
               cnt <= half_cyc - 1'b1;
               if (bitn == BIT_W'(FRAME_W)) begin
                  cs_q  <= 1'b1;
                  state <= ST_FIN;
               end else begin
                  sclk_q <= 1'b0;
                  tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
                  state  <= ST_LOW;
               end
            end else cnt <= cnt - 1'b1;
            ST_FIN: begin
               done_q  <= 1'b1;
               rdata_q <= rx_q;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign rsp_rdata = rdata_q;
   assign rsp_done  = done_q;
   assign spi_cs_n  = cs_q;
   assign spi_sclk  = sclk_q;
   assign spi_mosi  = tx_q[FRAME_W-1];

   // R3: clock parked high outside a frame
   a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> spi_sclk);
   // R3: data steady across every rising edge
   a_r3_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sclk) |-> $stable(spi_mosi));
   // R7: chip select only falls once the gap timers released it
   a_r7_gap_respected: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> $past(gap_ready));
   // R8: completion is a single pulse
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   // R8: completion follows chip-select rise by one clock
   a_r8_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (spi_cs_n && $past(spi_cs_n) && !$past(spi_cs_n, 2) && !busy));
   // R9: never idle with chip select low
   a_r9_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n |-> busy);

endmodule

// File: tb/sensor_spi_master_tb.sv
`timescale 1ns/1ps
module sensor_spi_master_tb_top;

   localparam int HALF_FAST  = 50;
   localparam int HALF_NORM  = 125;
   localparam int STALL_FAST = 2250;
   localparam int STALL_NORM = 3000;
   localparam int PER_FAST   = 8000;
   localparam int PER_NORM   = 10500;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  smpl_code = 8'h00;
   logic [5:0]  req_addr = '0;
   logic [8:0]  req_wdata = '0;
   logic        req_write = 1'b0;
   logic        req_start = 1'b0;
   logic        busy;
   logic [15:0] rsp_rdata;
   logic        rsp_done;
   logic        spi_cs_n, spi_sclk, spi_mosi;
   logic        spi_miso = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sensor_spi_master dut_i (
      .clk(clk), .rst_n(rst_n), .smpl_code(smpl_code), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_write(req_write), .req_start(req_start),
      .busy(busy), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
      .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso));

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // expectations for the frame in flight
   logic [15:0] exp_cmd, exp_word, slave_word;
   int          exp_half = HALF_FAST;
   bit          exp_fast = 1'b1;
   string       ph_tag = "R4 fast phase";

   // slave model: MSB at chip-select fall, later bits after falling edges
   logic [15:0] sl_sh;
   int          sl_falls;
   always @(negedge spi_cs_n) begin
      sl_sh    = slave_word;
      spi_miso = sl_sh[15];
      sl_falls = 0;
   end
   always @(negedge spi_sclk) begin
      if (!spi_cs_n) begin
         sl_falls++;
         if (sl_falls > 1) begin
            sl_sh    = {sl_sh[14:0], 1'b0};
            spi_miso = sl_sh[15];
         end
      end
   end

   // per-clock reference monitor
   bit          mon_on = 1'b0;
   int          cyc = 0, t_fall = 0, t_rise = 0, t_edge = 0, rises = 0;
   int          stall_prev = 0, per_prev = 0;
   bit          seen_frame = 1'b0, first_edge = 1'b0;
   logic        pcs = 1'b1, psclk = 1'b1, pdone = 1'b0;
   logic [15:0] mosi_cap = '0;

   always @(negedge clk) begin
      if (mon_on) begin
         cyc++;
         if (!spi_cs_n) chk(busy == 1'b1, "R9 busy while selected", busy, 1);
         else           chk(spi_sclk == 1'b1, "R3 sclk idle high", spi_sclk, 1);
         if (pcs && !spi_cs_n) begin
            if (seen_frame) begin
               chk(cyc - t_rise >= stall_prev, "R7 stall", cyc - t_rise, stall_prev);
               chk(cyc - t_fall >= per_prev, "R7 period", cyc - t_fall, per_prev);
            end
            t_fall = cyc; t_edge = cyc; rises = 0; first_edge = 1'b1; mosi_cap = '0;
         end else if (!spi_cs_n && spi_sclk != psclk) begin
            chk(cyc - t_edge == exp_half, first_edge ? "R6 lead" : ph_tag,
                cyc - t_edge, exp_half);
            first_edge = 1'b0;
            t_edge = cyc;
            if (spi_sclk) begin
               mosi_cap = {mosi_cap[14:0], spi_mosi};
               rises++;
            end
         end else if (!pcs && spi_cs_n) begin
            chk(cyc - t_edge == exp_half, "R6 tail", cyc - t_edge, exp_half);
            chk(rises == 16, "R2 rising edge count", rises, 16);
            chk(mosi_cap == exp_cmd, "R1 command word", mosi_cap, exp_cmd);
            t_rise     = cyc;
            stall_prev = exp_fast ? STALL_FAST : STALL_NORM;
            per_prev   = exp_fast ? PER_FAST : PER_NORM;
            seen_frame = 1'b1;
         end
         if (rsp_done) begin
            chk(!pdone, "R8 single pulse", pdone, 0);
            chk(cyc == t_rise + 1, "R8 done timing", cyc - t_rise, 1);
            chk(!busy, "R8 busy low at done", busy, 0);
            chk(rsp_rdata == exp_word, "R2 read data", rsp_rdata, exp_word);
         end
         pcs = spi_cs_n; psclk = spi_sclk; pdone = rsp_done;
      end
   end

   task automatic xfer(input logic wr, input logic [5:0] a, input logic [8:0] d,
                       input logic [7:0] code, input logic [15:0] word, input bit flip_code);
      bit held;
      @(negedge clk);
      while (busy) @(negedge clk);
      held       = seen_frame;
      exp_cmd    = {wr, a, d};
      exp_word   = word;
      slave_word = word;
      exp_fast   = (code <= 8'h07);
      exp_half   = exp_fast ? HALF_FAST : HALF_NORM;
      ph_tag     = flip_code ? "R10 latched code phase" : (exp_fast ? "R4 fast phase" : "R5 normal phase");
      req_write  = wr; req_addr = a; req_wdata = d; smpl_code = code;
      req_start  = 1'b1;
      @(negedge clk);
      req_start  = 1'b0;
      if (flip_code) smpl_code = ~code;
      chk(busy == 1'b1, "R9 busy after start", busy, 1);
      if (held) begin
         repeat (100) @(negedge clk);
         chk(busy && spi_cs_n, "R9 start held during gap", {busy, spi_cs_n}, 2'b11);
      end
      while (!rsp_done) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk(spi_cs_n == 1'b1, "R11 cs high", spi_cs_n, 1);
      chk(spi_sclk == 1'b1, "R11 sclk high", spi_sclk, 1);
      chk(busy == 1'b0, "R11 busy low", busy, 0);
      chk(rsp_done == 1'b0, "R11 done low", rsp_done, 0);
      chk(rsp_rdata == 16'h0, "R11 rdata zero", rsp_rdata, 0);
      mon_on = 1'b1;
      xfer(1'b0, 6'h2A, 9'h000, 8'h07, 16'hA5C3, 1'b0);  // R4 boundary code
      xfer(1'b1, 6'h15, 9'h1B3, 8'h08, 16'h0001, 1'b0);  // R5 boundary code, held
      xfer(1'b0, 6'h3F, 9'h0AA, 8'h00, 16'h8000, 1'b1);  // R10 code changes mid-request
      xfer(1'b1, 6'h01, 9'h155, 8'hFF, 16'hFFFF, 1'b0);  // R5 top code
      repeat (20) @(negedge clk);
      chk(rsp_rdata == 16'hFFFF, "R2 rdata held after frame", rsp_rdata, 16'hFFFF);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule